// File: doc/BRIEF.md
# Fail-Safe Digital Output Controller

This block owns a bank of digital outputs that a host processor commands through a small register port. The host writes a command word and the block drives it onto the outputs. The block also compares each output with the level that comes back from the field and flags any bit that stays wrong for longer than a relay needs to switch. A per-output indicator vector shows the driven levels.

The host must also write a heartbeat register at regular intervals. If no heartbeat arrives within a programmable number of clocks, the block treats the processor as dead. It then forces every output to a safe pattern that the host programmed earlier. It holds that pattern until the host explicitly clears the condition. From reset until the first command write, the outputs also show the safe pattern. As a result, a processor that never starts leaves the field in a known state.

Register map (3-bit address): 0 = command word, 1 = safe pattern, 2 = heartbeat timeout in clocks (low 20 bits), 3 = heartbeat (any write), 4 = mismatch flags, 5 = control/status.

Top module: `safe_dout_ctrl`

## Requirements
- R1: After reset, all outputs show the safe-pattern reset value (all zeros by default). The mismatch flags, the timeout register and status bit 0 read zero. Status bit 1 (awaiting first command) reads one.
- R2: Until the first write to address 0, the outputs show the safe pattern. That first write stores the word, and the outputs carry it from the next clock on. Status bit 1 then reads zero.
- R3: In normal operation, a write to address 0 appears on the outputs after the next clock edge, and address 0 reads back that word. Writes to addresses 1, 3 and 4 leave the outputs unchanged.
- R4: Let T be the nonzero value in address 2. In normal operation, if T clocks pass after the last heartbeat write (or after entry to normal operation) with no new heartbeat write, the outputs switch to the safe pattern. A heartbeat write restarts the count. T = 0 disables the timeout.
- R5: The failsafe condition is latched, and status bit 0 reads one while it holds. Only a write to address 5 with bit 0 set releases it. The outputs then return to the stored command word and the heartbeat count restarts.
- R6: While failsafe is latched, writes to address 0 are ignored. The outputs, the address 0 readback and the word restored on release are all unaffected.
- R7: Address 1 can be written at any time. Whenever the outputs show the safe pattern, a new safe value appears on them after the next clock edge.
- R8: Flag i is set after field_rb[i] differs from field_out[i] on 8 consecutive clock edges. A run of 7 or fewer sets nothing, and any agreeing edge restarts the run.
- R9: Flags are sticky. They appear on mism_o and at address 4 and are cleared per bit by writing a one to that bit of address 4. A flag set in the same cycle as its clear stays set.
- R10: led_o always equals field_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational on bus_addr) |
| field_out | output | 32 | Output drive vector |
| field_rb | input | 32 | Levels read back from the field |
| led_o | output | 32 | Indicator vector |
| mism_o | output | 32 | Sticky mismatch flags |

## Verification
The assertions assume that field_rb and the register port are synchronous to clk and hold stable around each rising edge. They also assume that at most one register access happens per clock. The bench drives every input on the falling edge. It derives field_rb from field_out through an XOR mask that it changes only on falling edges, so a mismatch run has an exact, countable length. The timeout is set to a small value before any timing check, so the trip edge can be reached within the run.

// File: rtl/sdo_pkg.sv
// Shared types and register addresses for the safe digital output controller.
// Assumes a 3-bit register address space.
package sdo_pkg;
    typedef enum logic [1:0] {
        MODE_INIT = 2'd0,   // awaiting first command, safe pattern shown
        MODE_RUN  = 2'd1,   // command word driven
        MODE_TRIP = 2'd2    // heartbeat lost, safe pattern latched
    } mode_t;

    localparam logic [2:0] A_CMD  = 3'd0;
    localparam logic [2:0] A_SAFE = 3'd1;
    localparam logic [2:0] A_TMO  = 3'd2;
    localparam logic [2:0] A_KICK = 3'd3;
    localparam logic [2:0] A_MISM = 3'd4;
    localparam logic [2:0] A_CTRL = 3'd5;
endpackage

// File: rtl/sdo_regs.sv
// Register file: command word, safe pattern, timeout, read mux and write
// strobes for heartbeat, failsafe release and flag clearing.
// Assumes N >= TW and N >= 2; one access per clock.
module sdo_regs
    import sdo_pkg::*;
#(
    parameter int N        = 32,
    parameter int TW       = 20,
    parameter logic [N-1:0] SAFE_RST = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [2:0]    addr,
    input  logic [N-1:0]  wdata,
    input  mode_t         mode,
    input  logic [N-1:0]  sticky,
    output logic [N-1:0]  cmd_q,
    output logic [N-1:0]  safe_q,
    output logic [TW-1:0] tmo_q,
    output logic          cmd_wr,
    output logic          kick,
    output logic          clr_trip,
    output logic [N-1:0]  sclr,
    output logic [N-1:0]  rdata
);
    // Decode of write strobes.
    always_comb begin
        cmd_wr   = we && (addr == A_CMD);
        kick     = we && (addr == A_KICK);
        clr_trip = we && (addr == A_CTRL) && wdata[0];
        sclr     = (we && (addr == A_MISM)) ? wdata : '0;
    end

    // Stored registers; command writes are dropped while tripped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            safe_q <= SAFE_RST;
            tmo_q  <= '0;
        end else begin
            if (cmd_wr && mode != MODE_TRIP) cmd_q <= wdata;
            if (we && addr == A_SAFE)        safe_q <= wdata;
            if (we && addr == A_TMO)         tmo_q <= wdata[TW-1:0];
        end
    end

    // Read mux.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CMD:  rdata = cmd_q;
            A_SAFE: rdata = safe_q;
            A_TMO:  rdata = N'(tmo_q);
            A_MISM: rdata = sticky;
            A_CTRL: rdata = N'({mode == MODE_INIT, mode == MODE_TRIP});
            default: rdata = '0;
        endcase
    end

    // R6
    cmd_frozen_in_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TRIP) |=> $stable(cmd_q));
endmodule

// File: rtl/sdo_mode.sv
// Operating mode sequencer with heartbeat timer. Leaves INIT on the first
// command write, trips when the timeout elapses without a heartbeat and
// stays tripped until released. Assumes strobes are single-cycle.
module sdo_mode
    import sdo_pkg::*;
#(
    parameter int TW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic          kick,
    input  logic          clr_trip,
    input  logic [TW-1:0] tmo,
    output mode_t         mode
);
    logic [TW-1:0] cnt_q;

    // Mode transitions and clocks-since-heartbeat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= MODE_INIT;
            cnt_q <= '0;
        end else begin
            case (mode)
                MODE_INIT: begin
                    if (cmd_wr) mode <= MODE_RUN;
                    cnt_q <= '0;
                end
                MODE_RUN: begin
                    if (kick || tmo == '0) begin
                        cnt_q <= '0;
                    end else if (cnt_q >= tmo - TW'(1)) begin
                        mode  <= MODE_TRIP;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + TW'(1);
                    end
                end
                MODE_TRIP: begin
                    if (clr_trip) mode <= MODE_RUN;
                    cnt_q <= '0;
                end
                default: mode <= MODE_TRIP;
            endcase
        end
    end

    // R5
    trip_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TRIP && !clr_trip) |=> (mode == MODE_TRIP));
    // R4
    kick_holds_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && kick) |=> (mode == MODE_RUN));
    // R4
    zero_tmo_no_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && tmo == '0) |=> (mode == MODE_RUN));
    // R2
    init_never_trips_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_INIT) |=> (mode != MODE_TRIP));
endmodule

// File: rtl/sdo_rbchk.sv
// Readback comparator: per-output run counter of disagreeing clocks and a
// sticky flag set when a run reaches DEB. Assumes rb is synchronous to clk.
module sdo_rbchk #(
    parameter int N   = 32,
    parameter int DEB = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] drive,
    input  logic [N-1:0] rb,
    input  logic [N-1:0] sclr,
    output logic [N-1:0] sticky
);
    localparam int CW = (DEB > 1) ? $clog2(DEB) : 1;

    logic [N-1:0] diff;
    logic [N-1:0] hit;

    assign diff = drive ^ rb;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [CW-1:0] run_q;

        // Count consecutive disagreeing clocks, saturating at DEB-1.
        always_ff @(posedge clk) begin
            if (!rst_n)                      run_q <= '0;
            else if (!diff[i])               run_q <= '0;
            else if (run_q != CW'(DEB - 1))  run_q <= run_q + CW'(1);
        end

        assign hit[i] = diff[i] && (run_q == CW'(DEB - 1));
    end

    // Sticky flags: set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) sticky <= '0;
        else        sticky <= (sticky & ~sclr) | hit;
    end

    // R9
    sticky_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sticky | ~$past(sticky & ~sclr)) == '1));
    // R8
    set_needs_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sticky & ~$past(sticky) & ~$past(diff)) == '0));
endmodule

// File: rtl/safe_dout_ctrl.sv
// Top level: drives the command word or the safe pattern depending on the
// mode, mirrors it to the indicators and checks the field readback.
// Assumes all inputs synchronous to clk.
module safe_dout_ctrl
    import sdo_pkg::*;
#(
    parameter int N   = 32,
    parameter int TW  = 20,
    parameter int DEB = 8,
    parameter logic [N-1:0] SAFE_RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_we,
    input  logic [2:0]   bus_addr,
    input  logic [N-1:0] bus_wdata,
    output logic [N-1:0] bus_rdata,
    output logic [N-1:0] field_out,
    input  logic [N-1:0] field_rb,
    output logic [N-1:0] led_o,
    output logic [N-1:0] mism_o
);
    mode_t         mode;
    logic [N-1:0]  cmd_q, safe_q, sclr, sticky;
    logic [TW-1:0] tmo_q;
    logic          cmd_wr, kick, clr_trip;

    sdo_regs #(.N(N), .TW(TW), .SAFE_RST(SAFE_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .mode(mode), .sticky(sticky),
        .cmd_q(cmd_q), .safe_q(safe_q), .tmo_q(tmo_q),
        .cmd_wr(cmd_wr), .kick(kick), .clr_trip(clr_trip),
        .sclr(sclr), .rdata(bus_rdata)
    );

    sdo_mode #(.TW(TW)) u_mode (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .kick(kick),
        .clr_trip(clr_trip), .tmo(tmo_q), .mode(mode)
    );

    // Output select: command only in normal operation.
    always_comb begin
        field_out = (mode == MODE_RUN) ? cmd_q : safe_q;
        led_o     = field_out;
    end

    sdo_rbchk #(.N(N), .DEB(DEB)) u_rbchk (
        .clk(clk), .rst_n(rst_n), .drive(field_out), .rb(field_rb),
        .sclr(sclr), .sticky(sticky)
    );

    assign mism_o = sticky;

    // R7
    safe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_RUN && !cmd_wr && !bus_we) |=> (field_out == $past(safe_q)));
endmodule

// File: tb/tb_safe_dout_ctrl.sv
module tb_safe_dout_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, field_out, led_o, mism_o, field_rb;
    logic [31:0] rb_flip = '0;
    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;   // 125 MHz

    assign field_rb = field_out ^ rb_flip;

    safe_dout_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .field_out(field_out),
        .field_rb(field_rb), .led_o(led_o), .mism_o(mism_o)
    );

    localparam int NV = 8;
    localparam logic [2:0]  VA [NV] = '{3'd0, 3'd0, 3'd1, 3'd0, 3'd3, 3'd0, 3'd4, 3'd0};
    localparam logic [31:0] VD [NV] = '{32'hFFFFFFFF, 32'h00000000, 32'h0F0F0F0F, 32'h80000001,
                                        32'hDEADBEEF, 32'h55AA55AA, 32'hFFFFFFFF, 32'hC3C3C3C3};
    localparam logic [31:0] VE [NV] = '{32'hFFFFFFFF, 32'h00000000, 32'h00000000, 32'h80000001,
                                        32'h80000001, 32'h55AA55AA, 32'h55AA55AA, 32'hC3C3C3C3};
    localparam int T = 10;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        check("R1 out", field_out, 32'h0);
        check("R1 mism", mism_o, 32'h0);
        rd(3'd2, r); check("R1 tmo", r, 32'h0);
        rd(3'd5, r); check("R1 status", r, 32'h2);
        // R7 safe pattern visible in INIT
        wr(3'd1, 32'hA5A5A5A5);
        check("R7 init safe", field_out, 32'hA5A5A5A5);
        // R2 first command leaves INIT
        wr(3'd0, 32'h12345678);
        check("R2 first cmd", field_out, 32'h12345678);
        rd(3'd5, r); check("R2 status", r, 32'h0);
        // R3 vector table
        for (int i = 0; i < NV; i++) begin
            wr(VA[i], VD[i]);
            check("R3 table out", field_out, VE[i]);
            check("R10 led", led_o, VE[i]);
        end
        rd(3'd0, r); check("R3 readback", r, 32'hC3C3C3C3);
        // R4 keep-alive heartbeats
        wr(3'd2, T);
        for (int k = 0; k < 8; k++) begin
            wr(3'd3, 32'h0);
            repeat (4) @(negedge clk);
        end
        check("R4 alive", field_out, 32'hC3C3C3C3);
        // R4 exact trip edge
        wr(3'd3, 32'h0);
        repeat (T - 1) @(negedge clk);
        check("R4 before timeout", field_out, 32'hC3C3C3C3);
        @(negedge clk);
        check("R4 at timeout", field_out, 32'h0F0F0F0F);
        // R5 latched
        repeat (30) @(negedge clk);
        wr(3'd3, 32'h0);
        rd(3'd5, r); check("R5 status", r, 32'h1);
        check("R5 still safe", field_out, 32'h0F0F0F0F);
        // R7 safe change while tripped
        wr(3'd1, 32'h11112222);
        check("R7 trip safe", field_out, 32'h11112222);
        // R6 command ignored
        wr(3'd0, 32'h99999999);
        check("R6 out", field_out, 32'h11112222);
        rd(3'd0, r); check("R6 readback", r, 32'hC3C3C3C3);
        // R5 release
        wr(3'd5, 32'h1);
        check("R5 released", field_out, 32'hC3C3C3C3);
        wr(3'd2, 32'h0);
        repeat (40) @(negedge clk);
        check("R4 disabled", field_out, 32'hC3C3C3C3);
        // R8 run of 7 does not set, interrupted run does not set
        @(negedge clk); rb_flip = 32'h20;
        repeat (7) @(negedge clk);
        rb_flip = 32'h0;
        @(negedge clk); rb_flip = 32'h20;
        repeat (7) @(negedge clk);
        rb_flip = 32'h0;
        check("R8 short runs", mism_o, 32'h0);
        // R8 run of 8 sets
        rb_flip = 32'h8;
        repeat (7) @(negedge clk);
        check("R8 seven edges", mism_o, 32'h0);
        @(negedge clk);
        check("R8 eight edges", mism_o, 32'h8);
        rb_flip = 32'h0;
        repeat (3) @(negedge clk);
        rd(3'd4, r); check("R9 sticky read", r, 32'h8);
        // R9 clear
        wr(3'd4, 32'h8);
        check("R9 cleared", mism_o, 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule